// File: doc/BRIEF.md
# SPI Status Autopoll Engine with Interrupt Unit

This block waits on a slow SPI device without software in the loop. It repeatedly sends a single command byte to the device and takes back one response byte. It then tests one selected bit of that response against an expected value. Polling stops on the first match, or when a try budget set at start-up runs out. Software arms the engine with a single 32-bit configuration write. While polling is in progress, bit 31 of the readback reads 1. After that, software waits for the interrupt line.

The byte exchange with the SPI shift engine uses two valid/ready streams. The command stream (`tx_*`) raises `tx_valid` with the byte on `tx_data` and holds both, unchanged, until `tx_ready` is seen high at a clock edge. The shift engine may hold `tx_ready` low for any number of cycles. The response stream (`rx_*`) raises `rx_ready` only while one response byte is awaited. A byte transfers on the edge where `rx_valid` and `rx_ready` are both high. The device side may delay `rx_valid` for as long as it needs. `spi_cs` frames each try.

Three event sources feed an interrupt unit: try completed, match found, and budget exhausted. Each source has a mask bit and a sticky status bit, and the unit drives one combined interrupt line.

Top module: `apoll_top`

## Requirements
- R1: A configuration write with bit 31 set, made while idle, starts polling. Bit 31 of `cfg_rdata` reads 1 from the next cycle until polling ends. The readback returns the stored fields at their fixed positions: command in bits 7:0, timeout in bits 19:16, bit select in bits 26:24 and polarity in bit 30.
- R2: Each try offers the command byte on the `tx` stream. `tx_valid` and `tx_data` stay steady until `tx_ready` is seen. The try then accepts exactly one byte on the `rx` stream.
- R3: `spi_cs` is high from the start of a try until its response byte is accepted. It is low for at least one cycle between two tries.
- R4: When response bit [bit select] equals the polarity bit, polling stops with no further try, status bit 1 (success) is set, and busy clears.
- R5: The try budget is (31 << `clk_sel`) + timeout, taken when polling starts. After that many tries with no match, status bit 2 (timeout) is set and busy clears. A match on the last allowed try counts as success.
- R6: Every completed try sets status bit 0 (try done).
- R7: Configuration writes made while polling is in progress are ignored: the command sent and the readback fields are unchanged.
- R8: A configuration write with bit 31 clear stores the fields but starts no try.
- R9: Status bits stay set until cleared by software. A mask bit of 1 keeps its source off `irq`. `irq` is high when any set status bit has its mask bit at 0.
- R10: Writing 1 to a status bit through `stat_we` clears it, and writing 0 leaves it unchanged. If a set event arrives in the same cycle as a clear, the bit ends up set.
- R11: After reset, status, mask, busy, `spi_cs`, `tx_valid`, `rx_ready` and `irq` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clk_sel | input | 3 | Clock select code; sets the budget shift |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration readback, with busy in bit 31 |
| mask_we | input | 1 | Mask write strobe |
| mask_wdata | input | 3 | Mask bits (1 = source disabled) |
| stat_we | input | 1 | Status clear strobe |
| stat_wdata | input | 3 | Write-one-to-clear bits |
| int_stat | output | 3 | Status: bit 0 try done, bit 1 success, bit 2 timeout |
| irq | output | 1 | Combined interrupt |
| tx_valid | output | 1 | Command byte offered |
| tx_ready | input | 1 | Shift engine takes the command byte |
| tx_data | output | 8 | Command byte |
| rx_valid | input | 1 | Response byte offered |
| rx_ready | output | 1 | Engine awaits a response byte |
| rx_data | input | 8 | Response byte |
| spi_cs | output | 1 | Device select, high during a try |

## Verification
The bench builds the block with its default widths: a 3-bit clock select and a 4-bit timeout field. With these, a clock select of 0 or 1 gives budgets of 31 to 77 tries. That is small enough to run complete timeout sequences and to place a match on the exact last try. A device model replies with bytes in which only the selected bit differs from the rest, so a wrong bit select or an inverted polarity changes the outcome. The bench also holds `tx_ready` low on alternate cycles and issues a status clear during a try-completion cycle.

// File: rtl/apoll_pkg.sv
package apoll_pkg;
  localparam int CMD_LSB = 0;
  localparam int CMD_W   = 8;
  localparam int TO_LSB  = 16;
  localparam int SEL_LSB = 24;
  localparam int SEL_W   = 3;
  localparam int POL_BIT = 30;
  localparam int GO_BIT  = 31;
  localparam int NSRC    = 3;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SEND,
    ST_RECV,
    ST_EVAL
  } poll_state_e;
endpackage

// File: rtl/apoll_engine.sv
module apoll_engine
  import apoll_pkg::*;
#(
  parameter int TO_W   = 4,
  parameter int CSEL_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CSEL_W-1:0]  clk_sel,
  input  logic               cfg_we,
  input  logic [31:0]        cfg_wdata,
  output logic [31:0]        cfg_rdata,
  output logic               tx_valid,
  input  logic               tx_ready,
  output logic [CMD_W-1:0]   tx_data,
  input  logic               rx_valid,
  output logic               rx_ready,
  input  logic [CMD_W-1:0]   rx_data,
  output logic               spi_cs,
  output logic               ev_done,
  output logic               ev_ok,
  output logic               ev_tmo
);
  // Budget counter wide enough for 31 << (2**CSEL_W - 1) plus the timeout field.
  localparam int MAX_SH = (1 << CSEL_W) - 1;
  localparam int CNT_W  = 5 + MAX_SH + 1;

  poll_state_e          st_q;
  logic [CMD_W-1:0]     cmd_q;
  logic [TO_W-1:0]      to_q;
  logic [SEL_W-1:0]     sel_q;
  logic                 pol_q;
  logic                 hit_q;
  logic [CNT_W-1:0]     cnt_q;
  logic [CNT_W-1:0]     lim_q;
  logic [CNT_W-1:0]     lim_w;
  logic                 last_w;
  logic                 busy;

  assign lim_w  = (CNT_W'(31) << clk_sel) + CNT_W'(cfg_wdata[TO_LSB +: TO_W]);
  assign last_w = (cnt_q + CNT_W'(1)) == lim_q;
  assign busy   = (st_q != ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cmd_q <= '0;
      to_q  <= '0;
      sel_q <= '0;
      pol_q <= 1'b0;
      hit_q <= 1'b0;
      cnt_q <= '0;
      lim_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (cfg_we) begin
          cmd_q <= cfg_wdata[CMD_LSB +: CMD_W];
          to_q  <= cfg_wdata[TO_LSB +: TO_W];
          sel_q <= cfg_wdata[SEL_LSB +: SEL_W];
          pol_q <= cfg_wdata[POL_BIT];
          if (cfg_wdata[GO_BIT]) begin
            lim_q <= lim_w;
            cnt_q <= '0;
            st_q  <= ST_SEND;
          end
        end
        ST_SEND: if (tx_ready) st_q <= ST_RECV;
        ST_RECV: if (rx_valid) begin
          hit_q <= (rx_data[sel_q] == pol_q);
          st_q  <= ST_EVAL;
        end
        ST_EVAL: begin
          if (hit_q || last_w) begin
            st_q <= ST_IDLE;
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
            st_q  <= ST_SEND;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign tx_valid = (st_q == ST_SEND);
  assign tx_data  = cmd_q;
  assign rx_ready = (st_q == ST_RECV);
  assign spi_cs   = (st_q == ST_SEND) || (st_q == ST_RECV);
  assign ev_done  = (st_q == ST_EVAL);
  assign ev_ok    = ev_done && hit_q;
  assign ev_tmo   = ev_done && !hit_q && last_w;

  always_comb begin
    cfg_rdata                         = '0;
    cfg_rdata[CMD_LSB +: CMD_W]       = cmd_q;
    cfg_rdata[TO_LSB +: TO_W]         = to_q;
    cfg_rdata[SEL_LSB +: SEL_W]       = sel_q;
    cfg_rdata[POL_BIT]                = pol_q;
    cfg_rdata[GO_BIT]                 = busy;
  end
endmodule

// File: rtl/apoll_irq.sv
module apoll_irq
  import apoll_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] ev,
  input  logic            mask_we,
  input  logic [NSRC-1:0] mask_wdata,
  input  logic            stat_we,
  input  logic [NSRC-1:0] stat_wdata,
  output logic [NSRC-1:0] stat,
  output logic            irq
);
  logic [NSRC-1:0] mask_q;
  logic [NSRC-1:0] stat_q;
  logic [NSRC-1:0] live;

  always_ff @(posedge clk) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_we) mask_q <= mask_wdata;
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    always_ff @(posedge clk) begin
      if (!rst_n)                        stat_q[i] <= 1'b0;
      else if (ev[i])                    stat_q[i] <= 1'b1;
      else if (stat_we && stat_wdata[i]) stat_q[i] <= 1'b0;
    end
    assign live[i] = stat_q[i] && !mask_q[i];
  end

  assign stat = stat_q;
  assign irq  = |live;
endmodule

// File: rtl/apoll_top.sv
module apoll_top
  import apoll_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  clk_sel,
  input  logic        cfg_we,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  input  logic        mask_we,
  input  logic [2:0]  mask_wdata,
  input  logic        stat_we,
  input  logic [2:0]  stat_wdata,
  output logic [2:0]  int_stat,
  output logic        irq,
  output logic        tx_valid,
  input  logic        tx_ready,
  output logic [7:0]  tx_data,
  input  logic        rx_valid,
  output logic        rx_ready,
  input  logic [7:0]  rx_data,
  output logic        spi_cs
);
  logic ev_done, ev_ok, ev_tmo;

  apoll_engine #(.TO_W(4), .CSEL_W(3)) u_eng (
    .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .spi_cs(spi_cs), .ev_done(ev_done), .ev_ok(ev_ok), .ev_tmo(ev_tmo)
  );

  apoll_irq u_irq (
    .clk(clk), .rst_n(rst_n), .ev({ev_tmo, ev_ok, ev_done}),
    .mask_we(mask_we), .mask_wdata(mask_wdata),
    .stat_we(stat_we), .stat_wdata(stat_wdata),
    .stat(int_stat), .irq(irq)
  );
endmodule

// File: rtl/apoll_chk.sv
module apoll_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_we,
  input logic [31:0] cfg_wdata,
  input logic [31:0] cfg_rdata,
  input logic        stat_we,
  input logic [2:0]  int_stat,
  input logic        irq,
  input logic        tx_valid,
  input logic        tx_ready,
  input logic [7:0]  tx_data,
  input logic        rx_valid,
  input logic        rx_ready,
  input logic        spi_cs
);
  p_go_sets_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_wdata[31] && !cfg_rdata[31]) |=> cfg_rdata[31]);

  p_tx_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

  p_cs_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_ready) |=> !spi_cs);

  p_end_has_result_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cfg_rdata[31]) |-> (int_stat[1] || int_stat[2]));

  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_rdata[31] |-> (!tx_valid && !spi_cs));

  p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_we |=> ((int_stat & $past(int_stat)) == $past(int_stat)));

  p_irq_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (int_stat != 3'b000));
endmodule

bind apoll_top apoll_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
  .cfg_rdata(cfg_rdata), .stat_we(stat_we), .int_stat(int_stat), .irq(irq),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
  .rx_valid(rx_valid), .rx_ready(rx_ready), .spi_cs(spi_cs)
);

// File: tb/apoll_top_tb.sv
`timescale 1ns/1ps
module apoll_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  clk_sel = '0;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        mask_we = 1'b0;
  logic [2:0]  mask_wdata = '0;
  logic        stat_we = 1'b0;
  logic [2:0]  stat_wdata = '0;
  logic [2:0]  int_stat;
  logic        irq;
  logic        tx_valid;
  logic        tx_ready = 1'b0;
  logic [7:0]  tx_data;
  logic        rx_valid = 1'b0;
  logic        rx_ready;
  logic [7:0]  rx_data = '0;
  logic        spi_cs;

  always #2 clk = ~clk;

  apoll_top u_dut (
    .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .mask_we(mask_we), .mask_wdata(mask_wdata),
    .stat_we(stat_we), .stat_wdata(stat_wdata),
    .int_stat(int_stat), .irq(irq),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .spi_cs(spi_cs)
  );

  int checks = 0;
  int errors = 0;
  bit done_all = 0;

  // scoreboard and device model state
  logic [7:0] exp_q[$];
  int  try_idx = 0;
  int  g_hit = -1;
  int  g_sel = 0;
  bit  g_pol = 1'b0;
  bit  g_stall = 1'b0;
  bit  gap_seen = 1'b1;
  bit  exp_ok = 1'b0;
  int  exp_tries = 0;
  logic [2:0] g_mask = '0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Device model and scoreboard monitor
  initial begin
    bit tx_hs = 0, rx_hs = 0;
    logic [7:0] m;
    forever begin
      @(negedge clk);
      if (rx_hs) rx_valid = 1'b0;
      if (tx_hs) begin
        m = 8'h01 << g_sel;
        if (try_idx - 1 == g_hit) rx_data = g_pol ? m : ~m;
        else                      rx_data = g_pol ? ~m : m;
        rx_valid = 1'b1;
      end
      tx_ready = g_stall ? ~tx_ready : 1'b1;
      #1;
      if (!spi_cs && cfg_rdata[31]) gap_seen = 1'b1;
      tx_hs = tx_valid && tx_ready;
      rx_hs = rx_valid && rx_ready;
      if (tx_hs) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R5 extra try beyond budget or after match", try_idx, exp_tries);
        end else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          chk(tx_data == e, "R2 command byte", tx_data, e);
        end
        if (try_idx > 0) chk(gap_seen, "R3 chip select low between tries", 0, 1);
        gap_seen = 1'b0;
        try_idx++;
      end
    end
  end

  task automatic wr_cfg(input logic [31:0] d);
    cfg_we = 1'b1; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic poll_start(input logic [7:0] cmd, input int sel, input bit pol,
                            input int to, input int csel, input int hit, input bit stall);
    int lim;
    lim = (31 << csel) + to;
    exp_ok = (hit >= 0) && (hit < lim);
    exp_tries = exp_ok ? hit + 1 : lim;
    g_hit = hit; g_sel = sel; g_pol = pol; g_stall = stall;
    try_idx = 0; gap_seen = 1'b1;
    exp_q.delete();
    for (int i = 0; i < exp_tries; i++) exp_q.push_back(cmd);
    clk_sel = 3'(csel);
    wr_cfg({1'b1, pol, 3'b000, 3'(sel), 4'b0000, 4'(to), 8'h00, cmd});
    chk(cfg_rdata[31] == 1'b1, "R1 busy after start", cfg_rdata[31], 1);
  endtask

  task automatic poll_finish;
    int n;
    logic [2:0] es;
    n = 0;
    while (cfg_rdata[31] && n < 20000) begin
      @(negedge clk);
      n++;
    end
    chk(!cfg_rdata[31], "R1 busy clears at end", cfg_rdata[31], 0);
    chk(try_idx == exp_tries, exp_ok ? "R4 try count" : "R5 try count", try_idx, exp_tries);
    chk(exp_q.size() == 0, "R5 tries missing", exp_q.size(), 0);
    es = {!exp_ok, exp_ok, 1'b1};
    chk(int_stat[0] == 1'b1, "R6 try done status", int_stat, es);
    chk(int_stat[1] == exp_ok, "R4 success status", int_stat, es);
    chk(int_stat[2] == !exp_ok, "R5 timeout status", int_stat, es);
    chk(irq == |(es & ~g_mask), "R9 irq level", irq, |(es & ~g_mask));
    g_stall = 1'b0;
  endtask

  task automatic clear_all;
    stat_we = 1'b1; stat_wdata = 3'b111;
    @(negedge clk);
    stat_we = 1'b0; stat_wdata = '0;
    chk(int_stat == 3'b000, "R10 clear all", int_stat, 0);
    chk(irq == 1'b0, "R10 irq drops after clear", irq, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk(int_stat == 3'b000, "R11 status", int_stat, 0);
    chk(irq == 1'b0, "R11 irq", irq, 0);
    chk(cfg_rdata[31] == 1'b0, "R11 busy", cfg_rdata[31], 0);
    chk(!spi_cs && !tx_valid && !rx_ready, "R11 stream idle", {spi_cs, tx_valid, rx_ready}, 0);

    // R4: match on first try
    poll_start(8'hA5, 3, 1'b1, 0, 0, 0, 1'b0);
    poll_finish();
    clear_all();

    // R4: match on try 5, polarity 0, top bit, with back-pressure (R2)
    poll_start(8'h3C, 7, 1'b0, 9, 0, 4, 1'b1);
    poll_finish();
    clear_all();

    // R5: timeout, budget 31+2
    poll_start(8'h9F, 0, 1'b1, 2, 0, -1, 1'b0);
    poll_finish();
    clear_all();

    // R5: shifted budget 62+5, with stall
    poll_start(8'h05, 5, 1'b0, 5, 1, -1, 1'b1);
    poll_finish();
    clear_all();

    // R5: match on the exact last allowed try is success
    poll_start(8'h77, 2, 1'b1, 0, 0, 30, 1'b0);
    poll_finish();
    clear_all();

    // R7: write during polling is ignored
    poll_start(8'h6E, 1, 1'b1, 0, 0, -1, 1'b0);
    repeat (10) @(negedge clk);
    wr_cfg(32'h8300_0011);
    chk(cfg_rdata[7:0] == 8'h6E, "R7 command kept", cfg_rdata[7:0], 8'h6E);
    chk(cfg_rdata[26:24] == 3'd1, "R7 select kept", cfg_rdata[26:24], 1);
    poll_finish();
    clear_all();

    // R8: write without go bit stores fields only
    wr_cfg(32'h4703_0011);
    chk(cfg_rdata == 32'h4703_0011, "R8 fields stored", cfg_rdata, 32'h4703_0011);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk(!tx_valid && !cfg_rdata[31], "R8 no try started", {tx_valid, cfg_rdata[31]}, 0);
    end

    // R9 / R10: masking and partial clear
    g_mask = 3'b111;
    mask_we = 1'b1; mask_wdata = 3'b111;
    @(negedge clk);
    mask_we = 1'b0;
    poll_start(8'h42, 4, 1'b1, 0, 0, 1, 1'b0);
    poll_finish();
    chk(irq == 1'b0, "R9 fully masked irq low", irq, 0);
    g_mask = 3'b101;
    mask_we = 1'b1; mask_wdata = 3'b101;
    @(negedge clk);
    mask_we = 1'b0;
    chk(irq == 1'b1, "R9 unmasked success raises irq", irq, 1);
    stat_we = 1'b1; stat_wdata = 3'b010;
    @(negedge clk);
    stat_we = 1'b0; stat_wdata = '0;
    chk(int_stat == 3'b001, "R10 partial clear", int_stat, 3'b001);
    chk(irq == 1'b0, "R9 masked done bit keeps irq low", irq, 0);
    clear_all();
    g_mask = 3'b000;
    mask_we = 1'b1; mask_wdata = 3'b000;
    @(negedge clk);
    mask_we = 1'b0;

    // R10: set event wins over a clear in the same cycle
    poll_start(8'h55, 2, 1'b1, 0, 0, 3, 1'b0);
    begin
      int gaps;
      gaps = 0;
      while (gaps < 2) begin
        @(negedge clk);
        #1;
        if (!spi_cs && cfg_rdata[31]) gaps++;
      end
    end
    stat_we = 1'b1; stat_wdata = 3'b111;
    @(negedge clk);
    stat_we = 1'b0; stat_wdata = '0;
    chk(int_stat[0] == 1'b1, "R10 set wins over clear", int_stat[0], 1);
    poll_finish();
    clear_all();

    done_all = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_all) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule